// File: doc/BRIEF.md
# Multiprocessor Asynchronous Serial Port

A full-duplex asynchronous serial port that software controls through one 8-bit control/status register and one data register. It carries eight data bits per frame, or nine when the extended mode is on. An address-filter option discards frames whose final level is 0. In 9-bit mode that level is the ninth bit, so a bus of several receivers can ignore data frames and wake only on address frames. In 8-bit mode the same option rejects frames with a bad stop bit.

A write to the data register starts a transmission. A read of the data register returns the last byte received. Two level flags in the control register signal that a frame was sent or was received. Only software clears them. Bit timing comes from an external tick that runs at sixteen times the bit rate. The port holds no FIFO, and baud generation and interrupt routing sit outside it.

Top module: `mpuart`

## Requirements
- R1: After reset the control register (address 0) reads 0x40, `txd` is 1, and `irq_tx` and `irq_rx` are 0.
- R2: Control bit 6 always reads 1, whatever was written to it. The other seven bits read back the value last written, unless hardware updated bits 2, 1 or 0 since that write.
- R3: When the transmitter is idle, a write to the data register (address 1) sends one frame on `txd`, least significant bit first. The frame is a 0 start bit, eight data bits, then (only when control bit 7 is 1) the value of control bit 3, then a 1 stop bit. Each bit lasts 16 baud ticks. A data write while a frame is in progress is ignored and sends nothing.
- R4: Control bit 1 (`irq_tx`) becomes 1 at the start of the stop bit. In 8-bit mode that is right after the eighth data bit, and in 9-bit mode right after the ninth bit. It is 0 during the last data bit when it was cleared before the frame.
- R5: With control bit 4 set, a received frame loads the data register. Control bit 2 takes the stop bit level in 8-bit mode, or the ninth bit in 9-bit mode. Control bit 0 (`irq_rx`) is set when the stop bit is sampled and is still 0 early in the stop bit.
- R6: With control bit 4 at 0, a frame on `rxd` changes neither the data register nor control bit 0.
- R7: In 8-bit mode with control bit 5 set, a frame whose stop bit is 0 leaves the data register and control bit 0 unchanged, and a frame with a stop bit of 1 is received. With bit 5 clear, a frame with a stop bit of 0 is received and bit 2 reads 0.
- R8: In 9-bit mode with control bit 5 set, a frame whose ninth bit is 0 is discarded, and a frame whose ninth bit is 1 is received with bit 2 at 1. With bit 5 clear, a ninth bit of 0 is received and bit 2 reads 0.
- R9: Once set, control bits 1 and 0 stay set until software writes 0 to them through the control register.
- R10: A low pulse on `rxd` shorter than half a bit period starts no frame, and the next valid frame is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| bus_addr | input | 1 | Register select: 0 control, 1 data |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the selected register (combinational) |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |
| irq_tx | output | 1 | Level copy of control bit 1 |
| irq_rx | output | 1 | Level copy of control bit 0 |

## Verification
The assertions check on every cycle that:
- a frame begins with a low level and `txd` moves only on a tick;
- the done pulse coincides with a high stop level;
- a disabled receiver never leaves idle;
- an accepted frame under the filter always has its final bit at 1;
- the flags stay set until a software write.

Only the bench scenarios can show the rest: the bit order and bit count on the wire, the exact point where each flag rises, which frames the filter keeps or discards, glitch rejection, and that a data write during a frame has no effect.

// File: rtl/mpuart_pkg.sv
package mpuart_pkg;
   typedef struct packed {
      logic nine_mode;
      logic fixed_one;
      logic filt_en;
      logic rx_en;
      logic tx_bit9;
      logic rx_bit9;
      logic tx_flag;
      logic rx_flag;
   } ctrl_t;

   localparam int unsigned DATA_W     = 8;
   localparam logic [7:0]  CTRL_RESET = 8'h40;
   localparam logic        ADDR_CTRL  = 1'b0;
   localparam logic        ADDR_DATA  = 1'b1;
endpackage

// File: rtl/mpuart_sync.sv
module mpuart_sync #(
   parameter int unsigned STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("mpuart_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RESET_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/mpuart_tx.sv
module mpuart_tx #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              load,
   input  logic [DATA_W-1:0] din,
   input  logic              nine_mode,
   input  logic              bit9,
   output logic              txd,
   output logic              done
);
   localparam int unsigned FRAME_MAX = DATA_W + 3;
   localparam int unsigned CW        = $clog2(OVS);
   localparam int unsigned BW        = $clog2(FRAME_MAX + 1);

   logic [FRAME_MAX-1:0] sh;
   logic [CW-1:0]        tcnt;
   logic [BW-1:0]        bcnt, last;
   logic                 busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         tcnt <= '0;
         bcnt <= '0;
         last <= '0;
         busy <= 1'b0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!busy && load) begin
            busy <= 1'b1;
            sh   <= {1'b1, (nine_mode ? bit9 : 1'b1), din, 1'b0};
            tcnt <= '0;
            bcnt <= '0;
            last <= nine_mode ? BW'(FRAME_MAX - 1) : BW'(FRAME_MAX - 2);
         end else if (busy && tick) begin
            if (tcnt == CW'(OVS - 1)) begin
               tcnt <= '0;
               sh   <= {1'b1, sh[FRAME_MAX-1:1]};
               bcnt <= bcnt + 1'b1;
               if (bcnt == last - 1'b1) done <= 1'b1;
               if (bcnt == last)        busy <= 1'b0;
            end else begin
               tcnt <= tcnt + 1'b1;
            end
         end
      end
   end

   assign txd = busy ? sh[0] : 1'b1;

   AST_TX_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && load) |=> (txd == 1'b0)); // R3
   AST_TX_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick && !load) |=> $stable(txd)); // R3
   AST_TX_DONE_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (txd == 1'b1)); // R4
endmodule

// File: rtl/mpuart_rx.sv
module mpuart_rx #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rxd_s,
   input  logic              en,
   input  logic              nine_mode,
   input  logic              filt_en,
   output logic              valid,
   output logic [DATA_W-1:0] dout,
   output logic              bit9
);
   localparam int unsigned CW = $clog2(OVS);
   localparam int unsigned BW = $clog2(DATA_W + 2);

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

   rx_state_t     state;
   logic [CW-1:0] tcnt;
   logic [BW-1:0] bcnt, nbits;
   logic [DATA_W:0] sh;
   logic          prev, mode9;
   logic          ninth_val;

   assign ninth_val = mode9 ? sh[DATA_W] : rxd_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         tcnt  <= '0;
         bcnt  <= '0;
         nbits <= '0;
         sh    <= '0;
         prev  <= 1'b1;
         mode9 <= 1'b0;
         valid <= 1'b0;
         dout  <= '0;
         bit9  <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (tick) begin
            prev <= rxd_s;
            unique case (state)
               RX_IDLE: begin
                  if (en && prev && !rxd_s) begin
                     state <= RX_START;
                     tcnt  <= '0;
                     mode9 <= nine_mode;
                     nbits <= nine_mode ? BW'(DATA_W + 1) : BW'(DATA_W);
                  end
               end
               RX_START: begin
                  if (tcnt == CW'(OVS/2 - 1)) begin
                     tcnt  <= '0;
                     bcnt  <= '0;
                     state <= rxd_s ? RX_IDLE : RX_BITS;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               RX_BITS: begin
                  if (tcnt == CW'(OVS - 1)) begin
                     tcnt <= '0;
                     if (bcnt == nbits) begin
                        state <= RX_IDLE;
                        if (!filt_en || ninth_val) begin
                           valid <= 1'b1;
                           dout  <= mode9 ? sh[DATA_W-1:0] : sh[DATA_W:1];
                           bit9  <= ninth_val;
                        end
                     end else begin
                        sh   <= {rxd_s, sh[DATA_W:1]};
                        bcnt <= bcnt + 1'b1;
                     end
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   AST_RX_IDLE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (state == RX_IDLE && !en) |=> (state == RX_IDLE)); // R6
   AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid); // R5
   AST_RX_FILTER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && $past(filt_en)) |-> bit9); // R7
endmodule

// File: rtl/mpuart.sv
module mpuart
   import mpuart_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              baud_tick,
   input  logic              bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              rxd,
   output logic              txd,
   output logic              irq_tx,
   output logic              irq_rx
);
   if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
      $error("mpuart: OVS must be even and at least 4");
   end

   ctrl_t             ctrl;
   logic [DATA_W-1:0] rx_buf;
   logic              rxd_s, tx_done, rx_valid, rx_b9;
   logic [DATA_W-1:0] rx_dout;
   logic              ctrl_wr, tx_load;

   assign ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
   assign tx_load = bus_wr && (bus_addr == ADDR_DATA);

   mpuart_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(rxd), .q(rxd_s));

   mpuart_tx #(.DATA_W(DATA_W), .OVS(OVS)) tx_i (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .load(tx_load),
      .din(bus_wdata), .nine_mode(ctrl.nine_mode), .bit9(ctrl.tx_bit9),
      .txd(txd), .done(tx_done));

   mpuart_rx #(.DATA_W(DATA_W), .OVS(OVS)) rx_i (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .rxd_s(rxd_s),
      .en(ctrl.rx_en), .nine_mode(ctrl.nine_mode), .filt_en(ctrl.filt_en),
      .valid(rx_valid), .dout(rx_dout), .bit9(rx_b9));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl   <= ctrl_t'(CTRL_RESET);
         rx_buf <= '0;
      end else begin
         if (ctrl_wr) begin
            ctrl           <= ctrl_t'(bus_wdata);
            ctrl.fixed_one <= 1'b1;
         end
         if (tx_done) ctrl.tx_flag <= 1'b1;
         if (rx_valid) begin
            ctrl.rx_flag <= 1'b1;
            ctrl.rx_bit9 <= rx_b9;
            rx_buf       <= rx_dout;
         end
      end
   end

   assign bus_rdata = (bus_addr == ADDR_CTRL) ? ctrl : rx_buf;
   assign irq_tx    = ctrl.tx_flag;
   assign irq_rx    = ctrl.rx_flag;

   AST_TX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.tx_flag && !ctrl_wr) |=> ctrl.tx_flag); // R9
   AST_RX_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.rx_flag && !ctrl_wr) |=> ctrl.rx_flag); // R9
   AST_RX_FLAG_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> ctrl.rx_flag); // R5
   AST_TX_FLAG_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> ctrl.tx_flag); // R4
   AST_BIT6_READS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == ADDR_CTRL) |-> bus_rdata[6]); // R2
endmodule

// File: tb/mpuart_tb_top.sv
module mpuart_tb_top;
   localparam int BIT_CLKS = 64;  // 16 ticks x 4 clocks

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       bus_addr = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       rxd = 1'b1;
   logic       txd, irq_tx, irq_rx;

   int n_chk = 0;
   int n_fail = 0;
   logic mon_busy = 1'b0;
   logic [9:0] txq[$];   // {mode9, bit9, data}

   always #2 clk = ~clk;

   mpuart dut_i (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .bus_addr(bus_addr),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rxd(rxd), .txd(txd), .irq_tx(irq_tx), .irq_rx(irq_rx));

   initial begin
      int cnt = 0;
      forever begin
         @(negedge clk);
         baud_tick = (cnt == 3);
         cnt = (cnt + 1) % 4;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic reg_read(input logic a, output logic [7:0] v);
      @(negedge clk);
      bus_addr = a;
      #1 v = bus_rdata;
   endtask

   // transmit monitor: pops expected frames and decodes txd at bit centres
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n && txd === 1'b0) begin
            logic [9:0] e;
            logic [7:0] got;
            logic       g9;
            mon_busy = 1'b1;
            if (txq.size() == 0) begin
               chk("R3 unexpected frame", 1, 0);
               e = 10'h0;
            end else e = txq.pop_front();
            repeat (BIT_CLKS/2) @(negedge clk);
            chk("R3 start bit", txd, 0);
            for (int i = 0; i < 8; i++) begin
               repeat (BIT_CLKS) @(negedge clk);
               got[i] = txd;
            end
            if (e[9]) begin
               repeat (BIT_CLKS) @(negedge clk);
               g9 = txd;
               chk("R3 ninth bit", g9, e[8]);
            end
            chk("R4 flag low in last data bit", irq_tx, 0);
            repeat (BIT_CLKS) @(negedge clk);
            chk("R3 stop bit", txd, 1);
            chk("R4 flag set in stop bit", irq_tx, 1);
            chk("R3 data bits", got, e[7:0]);
            repeat (BIT_CLKS/2) @(negedge clk);
            mon_busy = 1'b0;
         end
      end
   end

   task automatic tx_send(input logic m9, input logic b9, input logic [7:0] d);
      reg_write(1'b0, {m9, 1'b0, 2'b00, b9, 3'b000});
      txq.push_back({m9, b9, d});
      reg_write(1'b1, d);
      repeat (4) @(negedge clk);
      wait (!mon_busy);
   endtask

   task automatic rx_frame(input logic [7:0] d, input logic nine, input logic b9,
                           input logic stopv);
      @(negedge clk);
      rxd = 1'b0; repeat (BIT_CLKS) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = d[i]; repeat (BIT_CLKS) @(negedge clk);
      end
      if (nine) begin
         rxd = b9; repeat (BIT_CLKS) @(negedge clk);
      end
      rxd = stopv;
      repeat (8) @(negedge clk);
      chk("R5 flag low early in stop bit", irq_rx, 0);
      repeat (BIT_CLKS - 8) @(negedge clk);
      rxd = 1'b1;
      repeat (BIT_CLKS) @(negedge clk);
   endtask

   task automatic rx_expect(input string tag, input logic fl, input logic [7:0] d,
                            input logic b9);
      logic [7:0] c, v;
      reg_read(1'b0, c);
      reg_read(1'b1, v);
      chk({tag, " flag"}, c[0], fl);
      chk({tag, " data"}, v, d);
      chk({tag, " ninth/stop"}, c[2], b9);
   endtask

   initial begin
      logic [7:0] v;
      repeat (5) @(negedge clk);
      chk("R1 txd idle", txd, 1);
      chk("R1 irq_tx", irq_tx, 0);
      chk("R1 irq_rx", irq_rx, 0);
      rst_n = 1'b1;
      reg_read(1'b0, v);
      chk("R1 ctrl reset", v, 8'h40);

      reg_write(1'b0, 8'h00);
      reg_read(1'b0, v);
      chk("R2 bit6 forced", v, 8'h40);
      reg_write(1'b0, 8'hBF);
      reg_read(1'b0, v);
      chk("R2 readback", v, 8'hFF);
      reg_write(1'b0, 8'h00);
      reg_read(1'b0, v);
      chk("R9 sw clears flags", v, 8'h40);

      // R3/R4: 8-bit frames, bit3 = 0 so a wrongly sent ninth bit breaks the stop check
      tx_send(1'b0, 1'b0, 8'hA5);
      tx_send(1'b0, 1'b0, 8'h3C);
      // R3/R4: 9-bit frames
      tx_send(1'b1, 1'b1, 8'h5A);
      tx_send(1'b1, 1'b0, 8'hC3);

      // R3: data write while busy is ignored; R9: flag sticky
      reg_write(1'b0, 8'h00);
      txq.push_back({1'b0, 1'b0, 8'h81});
      reg_write(1'b1, 8'h81);
      repeat (200) @(negedge clk);
      reg_write(1'b1, 8'hFF);
      wait (!mon_busy);
      repeat (3*BIT_CLKS) @(negedge clk);
      chk("R3 no extra frame", txq.size(), 0);
      chk("R9 tx flag sticky", irq_tx, 1);
      reg_write(1'b0, 8'h00);
      chk("R9 tx flag cleared", irq_tx, 0);

      // R5: 8-bit receive
      reg_write(1'b0, 8'h10);
      rx_frame(8'h96, 1'b0, 1'b0, 1'b1);
      rx_expect("R5 8-bit", 1'b1, 8'h96, 1'b1);
      repeat (2*BIT_CLKS) @(negedge clk);
      chk("R9 rx flag sticky", irq_rx, 1);

      // R6: receiver disabled
      reg_write(1'b0, 8'h00);
      rx_frame(8'h11, 1'b0, 1'b0, 1'b1);
      rx_expect("R6 disabled", 1'b0, 8'h96, 1'b0);

      // R7: 8-bit stop check
      reg_write(1'b0, 8'h10);
      rx_frame(8'h22, 1'b0, 1'b0, 1'b0);
      rx_expect("R7 filter off stop0", 1'b1, 8'h22, 1'b0);
      reg_write(1'b0, 8'h30);
      rx_frame(8'h33, 1'b0, 1'b0, 1'b0);
      rx_expect("R7 filter on stop0", 1'b0, 8'h22, 1'b0);
      reg_write(1'b0, 8'h30);
      rx_frame(8'h44, 1'b0, 1'b0, 1'b1);
      rx_expect("R7 filter on stop1", 1'b1, 8'h44, 1'b1);

      // R5/R8: 9-bit receive and address filter
      reg_write(1'b0, 8'h90);
      rx_frame(8'h55, 1'b1, 1'b0, 1'b1);
      rx_expect("R8 filter off ninth0", 1'b1, 8'h55, 1'b0);
      reg_write(1'b0, 8'hB0);
      rx_frame(8'h66, 1'b1, 1'b0, 1'b1);
      rx_expect("R8 filter on ninth0", 1'b0, 8'h55, 1'b0);
      reg_write(1'b0, 8'hB0);
      rx_frame(8'h77, 1'b1, 1'b1, 1'b1);
      rx_expect("R8 filter on ninth1", 1'b1, 8'h77, 1'b1);

      // R10: glitch rejection
      reg_write(1'b0, 8'h10);
      @(negedge clk);
      rxd = 1'b0;
      repeat (BIT_CLKS/4) @(negedge clk);
      rxd = 1'b1;
      repeat (2*BIT_CLKS) @(negedge clk);
      rx_expect("R10 glitch ignored", 1'b0, 8'h77, 1'b0);
      rx_frame(8'h88, 1'b0, 1'b0, 1'b1);
      rx_expect("R10 frame after glitch", 1'b1, 8'h88, 1'b1);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=expired expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule